// File: doc/BRIEF.md
# CAN Interrupt Pending and Code Encoder

This block collects the interrupt sources of a CAN controller: one error source and fifteen message buffers. A single-cycle event pulse from a source sets a sticky pending flag. Software clears flags through a write-one-to-clear register. A separate enable mask selects which pending flags take part in a priority-encoded interrupt code.

Software reads the code from a status word. The status word holds a request bit, a 4-bit source code for the winning flag, and a 3-bit node-status field that is passed straight through from the protocol engine.

All registers are reached through a plain 16-bit register port. The port has a select strobe, a write strobe, a 2-bit register address, write data and combinational read data. There is no streaming data path, so the port carries no valid/ready handshake. A write is accepted in any cycle in which both the select and write strobes are high. Read data follows the address in the same cycle.

Top module: `can_irq_aggregator`

## Requirements
- R1: A high bit on `src_evt` in a cycle sets the matching pending flag at the next clock edge, and the flag stays set until cleared. Bit 15 is the error source and bit n (0..14) is message buffer n. The flags read at address 0.
- R2: A write to address 1 clears, at the next edge, each pending flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R3: Address 1 always reads as 0x0000. Writing 0x0000 to it leaves all pending flags unchanged.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Address 2 is a read/write enable mask with the same bit layout as the pending flags. Writing the mask never changes the pending flags.
- R6: When no flag is both pending and enabled, status bits 4:0 read 0.
- R7: An enabled, pending error flag gives request bit 1 and code 0000, whatever buffer flags are also pending.
- R8: When no enabled error is pending, the lowest-numbered buffer n that is both pending and enabled gives request bit 1 and code n+1.
- R9: The status word at address 3 is laid out as follows. Bits 7:5 carry `node_state` from the same cycle. Bit 4 is the request bit and bits 3:0 are the code. Bits 15:8 read 0.
- R10: Writes to addresses 0 and 3 change no register.
- R11: After reset, the pending flags and the enable mask are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 16 | Event pulses: bit 15 is the error source, bits 14:0 are buffers 0..14 |
| node_state | input | 3 | Node status from the protocol engine, shown in the status word |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 2 | Register address: 0 pending, 1 clear, 2 enable, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |

## Verification
The bound checker checks, on every clock edge, the rules that hold from cycle to cycle:
- events stick, and an event wins over a clear in the same cycle;
- a clearing write removes exactly the written ones;
- the flags and the mask hold when nothing touches them;
- the clear address reads zero;
- the status word tracks `node_state` and keeps its reserved bits at zero;
- the request bit follows the enabled pending set, and an enabled error forces code zero.

The exact buffer code, including the offset by one and the lowest-buffer-first ordering under mixed masks, is shown only by the bench's sweeps. So are the reset values and the fact that writes to the read-only addresses are ignored.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  // Register address map of the block's register port.
  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_CLR  = 2'd1,
    REG_CEN  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/can_irq_pending.sv
module can_irq_pending #(
  parameter int SRC_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] pend_o
);

  // One sticky flag per source; a set in the same cycle as a clear wins.
  for (genvar g = 0; g < SRC_N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (set_i[g])   flag_q <= 1'b1;
      else if (clr_i[g])   flag_q <= 1'b0;
    end
    assign pend_o[g] = flag_q;
  end

endmodule

// File: rtl/can_irq_mask.sv
module can_irq_mask #(
  parameter int SRC_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SRC_N-1:0] wdata_i,
  output logic [SRC_N-1:0] en_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_o <= '0;
    else if (we_i) en_o <= wdata_i;
  end

endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio #(
  parameter int NUM_BUF = 15,
  parameter int CODE_W  = 4
) (
  input  logic [NUM_BUF:0]    pend_i,
  input  logic [NUM_BUF:0]    en_i,
  output logic                irq_o,
  output logic [CODE_W-1:0]   code_o
);

  logic [NUM_BUF:0] active;

  always_comb begin
    active = pend_i & en_i;
    irq_o  = |active;
    code_o = '0;
    // Walk from the highest buffer down so the lowest pending buffer wins.
    for (int n = NUM_BUF - 1; n >= 0; n--) begin
      if (active[n]) code_o = CODE_W'(n + 1);
    end
    // The error source outranks every buffer and uses code zero.
    if (active[NUM_BUF]) code_o = '0;
  end

endmodule

// File: rtl/can_irq_aggregator.sv
module can_irq_aggregator #(
  parameter int NUM_BUF = 15,
  parameter int DATA_W  = 16,
  parameter int NS_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_BUF:0]                src_evt,
  input  logic [NS_W-1:0]                 node_state,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [1:0]                      bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata
);
  import can_irq_pkg::*;

  localparam int SRC_N  = NUM_BUF + 1;
  localparam int CODE_W = $clog2(NUM_BUF + 1);
  localparam int STAT_W = NS_W + 1 + CODE_W;

  reg_sel_e          sel;
  logic              wr_any;
  logic [SRC_N-1:0]  clr_vec;
  logic              en_we;
  logic [SRC_N-1:0]  pend_q;
  logic [SRC_N-1:0]  en_q;
  logic              irq;
  logic [CODE_W-1:0] code;
  logic [STAT_W-1:0] stat;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_any  = bus_sel && bus_wr;
  assign clr_vec = (wr_any && sel == REG_CLR) ? bus_wdata[SRC_N-1:0] : '0;
  assign en_we   = wr_any && sel == REG_CEN;

  can_irq_pending #(.SRC_N(SRC_N)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (src_evt),
    .clr_i  (clr_vec),
    .pend_o (pend_q)
  );

  can_irq_mask #(.SRC_N(SRC_N)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (en_we),
    .wdata_i (bus_wdata[SRC_N-1:0]),
    .en_o    (en_q)
  );

  can_irq_prio #(.NUM_BUF(NUM_BUF), .CODE_W(CODE_W)) u_prio (
    .pend_i (pend_q),
    .en_i   (en_q),
    .irq_o  (irq),
    .code_o (code)
  );

  assign stat = {node_state, irq, code};

  always_comb begin
    unique case (sel)
      REG_PEND: bus_rdata = DATA_W'(pend_q);
      REG_CLR:  bus_rdata = '0;
      REG_CEN:  bus_rdata = DATA_W'(en_q);
      REG_STAT: bus_rdata = DATA_W'(stat);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/can_irq_checker.sv
module can_irq_checker #(
  parameter int NUM_BUF = 15,
  parameter int DATA_W  = 16,
  parameter int NS_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_BUF:0]  src_evt,
  input logic [NS_W-1:0]   node_state,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_BUF:0]  pend_q,
  input logic [NUM_BUF:0]  en_q
);
  localparam int SRC_N  = NUM_BUF + 1;
  localparam int CODE_W = $clog2(NUM_BUF + 1);
  localparam int NS_LO  = CODE_W + 1;
  localparam int NS_HI  = CODE_W + NS_W;

  logic clr_wr, en_wr;
  assign clr_wr = bus_sel && bus_wr && bus_addr == 2'd1;
  assign en_wr  = bus_sel && bus_wr && bus_addr == 2'd2;

  // R1
  p_sticky_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

  // R4
  p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((src_evt & bus_wdata[SRC_N-1:0]) != '0))
      |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

  // R2
  p_clear_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && src_evt == '0)
      |=> (pend_q == ($past(pend_q) & ~$past(bus_wdata[SRC_N-1:0]))));

  // R10: no event and no clear write leaves the flags alone
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && src_evt == '0) |=> $stable(pend_q));

  // R5
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));

  // R3
  p_clear_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata == '0));

  // R9
  p_status_layout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata[DATA_W-1:NS_HI+1] == '0
                            && bus_rdata[NS_HI:NS_LO] == node_state));

  // R6
  p_request_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata[CODE_W] == |(pend_q & en_q)));

  // R7
  p_error_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3 && pend_q[NUM_BUF] && en_q[NUM_BUF])
      |-> (bus_rdata[CODE_W:0] == {1'b1, {CODE_W{1'b0}}}));

endmodule

bind can_irq_aggregator can_irq_checker #(
  .NUM_BUF (NUM_BUF),
  .DATA_W  (DATA_W),
  .NS_W    (NS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_evt    (src_evt),
  .node_state (node_state),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pend_q     (pend_q),
  .en_q       (en_q)
);

// File: tb/can_irq_aggregator_test.sv
module can_irq_aggregator_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_evt = '0;
  logic [2:0]  node_state = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  can_irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .node_state(node_state),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk);
    src_evt = v;
    @(negedge clk);
    src_evt = '0;
  endtask

  // Expected request bit and code: error first (code 0), else lowest buffer n -> n+1.
  function automatic logic [4:0] exp_code(input logic [15:0] p, input logic [15:0] e);
    logic [15:0] a;
    a = p & e;
    if (a[15]) return 5'b1_0000;
    for (int n = 0; n < 15; n++) if (a[n]) return {1'b1, 4'(n + 1)};
    return 5'b0;
  endfunction

  function automatic string code_req(input logic [15:0] p, input logic [15:0] e);
    logic [15:0] a;
    a = p & e;
    if (a == '0) return "R6";
    if (a[15])   return "R7";
    return "R8";
  endfunction

  task automatic vec(input logic [15:0] p, input logic [15:0] e);
    logic [15:0] r;
    wr(2'd1, 16'hFFFF);
    pulse(p);
    wr(2'd2, e);
    rd(2'd0, r); chk("R1", r, p);
    rd(2'd2, r); chk("R5", r, e);
    rd(2'd3, r); chk(code_req(p, e), {11'b0, r[4:0]}, {11'b0, exp_code(p, e)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    node_state = 3'b101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(2'd0, r); chk("R11", r, 16'h0000);
    rd(2'd2, r); chk("R11", r, 16'h0000);
    rd(2'd3, r); chk("R11", r, 16'h00A0);

    // R9 node_state pass-through, reserved zero
    for (int s = 0; s < 8; s++) begin
      node_state = 3'(s);
      rd(2'd3, r); chk("R9", r, 16'(s << 5));
    end
    node_state = 3'b010;

    // Single sources, full mask and masked-out
    for (int i = 0; i < 16; i++) begin
      vec(16'(1 << i), 16'hFFFF);
      vec(16'(1 << i), ~16'(1 << i));
    end
    // All pairs of sources, full mask
    for (int i = 0; i < 16; i++)
      for (int j = i + 1; j < 16; j++)
        vec(16'((1 << i) | (1 << j)), 16'hFFFF);
    // Arithmetic patterns with mixed masks
    for (int k = 0; k < 200; k++)
      vec(16'(k * 40503) ^ 16'(k << 3), (k % 3 == 0) ? 16'hFFFF : 16'(k * 28461 + 4951));

    // R2 selective clear
    wr(2'd1, 16'hFFFF);
    pulse(16'hA5C3);
    wr(2'd1, 16'h0F0F);
    rd(2'd0, r); chk("R2", r, 16'hA0C0);

    // R3 clear reads zero, zero write has no effect
    rd(2'd1, r); chk("R3", r, 16'h0000);
    wr(2'd1, 16'h0000);
    rd(2'd0, r); chk("R3", r, 16'hA0C0);

    // R4 set and clear on the same flag in the same cycle
    @(negedge clk);
    src_evt = 16'h0008; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'hFFFF;
    @(negedge clk);
    src_evt = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd(2'd0, r); chk("R4", r, 16'h0008);

    // R5 mask write leaves flags alone
    wr(2'd2, 16'h0000);
    rd(2'd0, r); chk("R5", r, 16'h0008);

    // R10 writes to pending and status addresses are ignored
    wr(2'd2, 16'h0008);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, r); chk("R10", r, 16'h0008);
    wr(2'd3, 16'h0000);
    rd(2'd3, r); chk("R10", r, 16'h0054);
    rd(2'd2, r); chk("R10", r, 16'h0008);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule